// File: doc/BRIEF.md
# Command and Status Flag Timing Unit

This unit sits between a processor write port and the transmit/receive engine of a network controller. The processor writes a command code. The unit holds the code, passes the write through a two-stage synchronizer that advances on the selected command clock, and presents the command to the engine as a one-cycle strobe. It also keeps two status flags, "transmitter available" and "receiver inhibited". A completion pulse from the engine sets each flag. The matching enable command clears it. The flags drive an active-low interrupt through a per-flag mask.

A mode bit, the early-flag option, controls two things. When it is clear, the command clock is an oversampling tick whose period is 2^rate_sel system cycles. In this mode a flag rises when the completion pulse starts, and enable commands for that channel are refused while the pulse is still high. When the bit is set, the command clock is the fixed system (crystal) clock and a flag rises only when the completion pulse ends, so there is no refusal window. Commands that come too early and refused enable commands are dropped and recorded in sticky error outputs. A prescaler setting that is illegal at high data rates is also recorded.

Top module: `cmdflag_timing_unit`

## Requirements
- R1: After reset: tx_avail=1, rx_inhib=1, irq_n=1, cmd_stb=0, ef_active=0, mask=00, and all three error outputs are 0.
- R2: With the early-flag mode active, a write sampled at clock edge E0 produces cmd_stb=1 with cmd_code equal to the written code for exactly the one cycle after edge E2.
- R3: A write that arrives while an earlier command is still pending is dropped and sets err_interval, which stays 1 until reset. In early-flag mode, a write sampled two edges after the previous one is rejected and a write sampled three edges after it is accepted.
- R4: With the early-flag mode inactive, the command clock ticks once every 2^rate_sel system cycles. At rate_sel=3, a second write 3 cycles after the first is rejected, and one 20 cycles after it is accepted.
- R5: A request to change the early-flag mode (ef_wr with ef_val) takes effect only in a cycle with no command pending. While a command is pending, ef_active keeps its old value.
- R6: With early-flag inactive, a flag rises on the first edge at which its completion pulse is seen high. While that pulse stays high, an enable command for that channel is dropped and sets the sticky err_prohibit.
- R7: With early-flag active, a flag stays low while its completion pulse is high and rises on the edge at which the pulse is first seen low. Enable commands written during the pulse are accepted and do not set err_prohibit.
- R8: An issued command with code 4'h3 (enable transmit) clears tx_avail. An issued command with code 4'h4 (enable receive) clears rx_inhib. All other codes leave both flags unchanged.
- R9: irq_n is 0 exactly when a flag is 1 and its mask bit is 1. Mask bit 0 belongs to tx_avail and bit 1 to rx_inhib. The mask is loaded by mask_wr.
- R10: err_rate goes to 1 on the edge after fast_rate=1 is seen together with a nonzero rate_sel, and it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (crystal) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 3 | Prescaler select; oversampling tick period is 2^rate_sel cycles |
| fast_rate | input | 1 | High when the data rate is above the prescaler-legal limit |
| ef_wr | input | 1 | Request to load the early-flag mode |
| ef_val | input | 1 | Requested early-flag mode value |
| cpu_wr | input | 1 | Command write strobe, one cycle |
| cpu_cmd | input | 4 | Command code written |
| mask_wr | input | 1 | Load the interrupt mask |
| mask_val | input | 2 | New mask; bit 0 transmit, bit 1 receive |
| tx_done | input | 1 | Transmit completion set pulse from the engine |
| rx_done | input | 1 | Receive completion set pulse from the engine |
| cmd_stb | output | 1 | One-cycle strobe issuing a command to the engine |
| cmd_code | output | 4 | Code of the issued command |
| ef_active | output | 1 | Early-flag mode currently in force |
| tx_avail | output | 1 | Transmitter-available flag |
| rx_inhib | output | 1 | Receiver-inhibited flag |
| irq_n | output | 1 | Active-low interrupt |
| err_interval | output | 1 | Sticky: command written before the previous one completed |
| err_prohibit | output | 1 | Sticky: enable command written inside the refusal window |
| err_rate | output | 1 | Sticky: nonzero prescaler select with a fast data rate |

## Verification
The assertions take for granted that cpu_wr, ef_wr and mask_wr are single-cycle pulses in the system clock domain. They also assume that a completion pulse stays high for several cycles, as the engine's set pulse does, and does not come back before it has been seen low. The bench drives every input on the falling edge, keeps each write strobe to one cycle, and holds each completion pulse for four to six cycles. It places writes at counted offsets from earlier writes and from pulse edges, so every accept or reject case can be predicted from the requirements.

// File: rtl/cfu_pkg.sv
// Package: shared constants for the command and status flag timing unit.
// Assumes a command code four bits wide and two status channels.
package cfu_pkg;
    localparam int CMD_W     = 4;
    localparam int NCH       = 2;
    localparam int CH_TX     = 0;
    localparam int CH_RX     = 1;
    localparam logic [CMD_W-1:0] CMD_EN_TX = 4'h3;
    localparam logic [CMD_W-1:0] CMD_EN_RX = 4'h4;
endpackage

// File: rtl/cfu_tick_gen.sv
// Module: oversampling tick generator and prescaler legality check.
// Produces one tick every 2^rate_sel cycles from a free-running counter.
// Assumes rate_sel is quasi-static. Records a sticky error when a nonzero
// select is used while the data rate is flagged as fast.
module cfu_tick_gen #(
    parameter int RSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RSEL_W-1:0] rate_sel,
    input  logic              fast_rate,
    output logic              tick_osc,
    output logic              err_rate
);
    localparam int PRE_W = (1 << RSEL_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_mask;

    // free-running prescaler count
    always_ff @(posedge clk) begin
        if (!rst_n) pre_cnt <= '0;
        else        pre_cnt <= pre_cnt + 1'b1;
    end

    // low rate_sel bits of the count must be zero for a tick
    always_comb begin
        pre_mask = ~({PRE_W{1'b1}} << rate_sel);
        tick_osc = ((pre_cnt & pre_mask) == '0);
    end

    // sticky record of an illegal prescaler select
    always_ff @(posedge clk) begin
        if (!rst_n)                                err_rate <= 1'b0;
        else if (fast_rate && (rate_sel != '0))    err_rate <= 1'b1;
    end

    AST_RATE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_rate && (rate_sel != '0)) |=> err_rate); // R10
    AST_RATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_rate |=> err_rate); // R10
endmodule

// File: rtl/cfu_flag_chan.sv
// Module: one status flag channel (transmit or receive).
// Sets the flag from the engine's completion pulse, either when the pulse
// starts (early mode off) or when it ends (early mode on), and clears it
// when the matching enable command is issued. A set wins over a clear
// in the same cycle. Assumes the pulse is in the system clock domain.
module cfu_flag_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic ef,
    input  logic done,
    input  logic en_clr,
    output logic flag,
    output logic prohibit
);
    logic done_q;
    logic set_evt;

    // previous pulse level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= done;
    end

    // select leading or trailing pulse edge by mode
    always_comb begin
        set_evt  = ef ? (!done && done_q) : (done && !done_q);
        prohibit = done && !ef;
    end

    // flag register: resets high, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b1;
        else if (set_evt) flag <= 1'b1;
        else if (en_clr)  flag <= 1'b0;
    end

    AST_SET_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!ef && done && !done_q) |=> flag); // R6
    AST_SET_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (ef && !done && done_q) |=> flag); // R7
    AST_HOLD_LOW_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ef && done && done_q && !flag) |=> !flag); // R7
endmodule

// File: rtl/cfu_cmd_path.sv
// Module: command holding register, synchronizer and issue logic.
// A processor write is held as pending. The first synchronizer flop samples
// the pending state on a selected-clock tick. The second stage is the
// issue strobe register, loaded on the next tick. Writes that arrive while
// pending, or enable commands inside a refusal window, are dropped and
// recorded. The early-flag mode changes only while nothing is pending.
module cfu_cmd_path
    import cfu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_osc,
    input  logic             cpu_wr,
    input  logic [CMD_W-1:0] cpu_cmd,
    input  logic             ef_wr,
    input  logic             ef_val,
    input  logic [NCH-1:0]   prohibit,
    output logic             cmd_stb,
    output logic [CMD_W-1:0] cmd_code,
    output logic [NCH-1:0]   en_clr,
    output logic             ef,
    output logic             err_interval,
    output logic             err_prohibit
);
    logic             pending;
    logic [CMD_W-1:0] hold_code;
    logic             sync_q;
    logic             ef_req;
    logic             tick_sel;
    logic [NCH-1:0]   wr_is_en;
    logic             wr_blocked;
    logic             accept;
    logic             issue;

    // decode the written code against each channel's enable command
    always_comb begin
        wr_is_en[CH_TX] = (cpu_cmd == CMD_EN_TX);
        wr_is_en[CH_RX] = (cpu_cmd == CMD_EN_RX);
        wr_blocked      = |(wr_is_en & prohibit);
        accept          = cpu_wr && !pending && !wr_blocked;
        tick_sel        = ef || tick_osc;
        issue           = tick_sel && pending && sync_q;
    end

    // hold the accepted command until it is issued
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            hold_code <= '0;
        end else if (accept) begin
            pending   <= 1'b1;
            hold_code <= cpu_cmd;
        end else if (issue) begin
            pending   <= 1'b0;
        end
    end

    // first synchronizer flop, advanced by the selected clock tick
    always_ff @(posedge clk) begin
        if (!rst_n)        sync_q <= 1'b0;
        else if (issue)    sync_q <= 1'b0;
        else if (tick_sel) sync_q <= pending;
    end

    // second stage: issue strobe and code to the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_stb  <= 1'b0;
            cmd_code <= '0;
        end else begin
            cmd_stb  <= issue;
            if (issue) cmd_code <= hold_code;
        end
    end

    // enable commands clear their flag when the strobe is presented
    always_comb begin
        en_clr[CH_TX] = cmd_stb && (cmd_code == CMD_EN_TX);
        en_clr[CH_RX] = cmd_stb && (cmd_code == CMD_EN_RX);
    end

    // mode request and application while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ef_req <= 1'b0;
            ef     <= 1'b0;
        end else begin
            if (ef_wr)    ef_req <= ef_val;
            if (!pending) ef     <= ef_req;
        end
    end

    // sticky error records for dropped writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_interval <= 1'b0;
            err_prohibit <= 1'b0;
        end else if (cpu_wr) begin
            if (pending)         err_interval <= 1'b1;
            else if (wr_blocked) err_prohibit <= 1'b1;
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb); // R2
    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && pending) |=> (err_interval && $stable(hold_code))); // R3
    AST_INTERVAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_interval |=> err_interval); // R3
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> $stable(ef)); // R5
    AST_WINDOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !pending && wr_blocked) |=> (err_prohibit && !pending)); // R6
endmodule

// File: rtl/cmdflag_timing_unit.sv
// Module: top of the command and status flag timing unit.
// Connects the tick generator, the command path and one flag channel per
// status flag, and forms the masked active-low interrupt. Assumes all
// inputs are synchronous to clk and write strobes last one cycle.
module cmdflag_timing_unit
    import cfu_pkg::*;
#(
    parameter int RSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RSEL_W-1:0] rate_sel,
    input  logic              fast_rate,
    input  logic              ef_wr,
    input  logic              ef_val,
    input  logic              cpu_wr,
    input  logic [CMD_W-1:0]  cpu_cmd,
    input  logic              mask_wr,
    input  logic [NCH-1:0]    mask_val,
    input  logic              tx_done,
    input  logic              rx_done,
    output logic              cmd_stb,
    output logic [CMD_W-1:0]  cmd_code,
    output logic              ef_active,
    output logic              tx_avail,
    output logic              rx_inhib,
    output logic              irq_n,
    output logic              err_interval,
    output logic              err_prohibit,
    output logic              err_rate
);
    logic           tick_osc;
    logic           ef;
    logic [NCH-1:0] done_vec;
    logic [NCH-1:0] flags;
    logic [NCH-1:0] prohibit;
    logic [NCH-1:0] en_clr;
    logic [NCH-1:0] irq_mask;

    cfu_tick_gen #(.RSEL_W(RSEL_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .fast_rate(fast_rate),
        .tick_osc (tick_osc),
        .err_rate (err_rate)
    );

    cfu_cmd_path u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_osc    (tick_osc),
        .cpu_wr      (cpu_wr),
        .cpu_cmd     (cpu_cmd),
        .ef_wr       (ef_wr),
        .ef_val      (ef_val),
        .prohibit    (prohibit),
        .cmd_stb     (cmd_stb),
        .cmd_code    (cmd_code),
        .en_clr      (en_clr),
        .ef          (ef),
        .err_interval(err_interval),
        .err_prohibit(err_prohibit)
    );

    // gather completion pulses by channel index
    always_comb begin
        done_vec[CH_TX] = tx_done;
        done_vec[CH_RX] = rx_done;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        cfu_flag_chan u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .ef      (ef),
            .done    (done_vec[ch]),
            .en_clr  (en_clr[ch]),
            .flag    (flags[ch]),
            .prohibit(prohibit[ch])
        );
    end

    // interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_mask <= '0;
        else if (mask_wr) irq_mask <= mask_val;
    end

    // outputs: flags, mode and masked interrupt
    always_comb begin
        tx_avail  = flags[CH_TX];
        rx_inhib  = flags[CH_RX];
        ef_active = ef;
        irq_n     = ~|(flags & irq_mask);
    end

    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && (mask_val == '0)) |=> irq_n); // R9
    AST_CLEAR_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && (cmd_code == CMD_EN_TX) && !tx_done && !ef) |=> !tx_avail); // R8
endmodule

// File: tb/sim_cmdflag_timing_unit.sv
// Directed bench for cmdflag_timing_unit: one task per scenario.
module sim_cmdflag_timing_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] rate_sel;
    logic       fast_rate, ef_wr, ef_val, cpu_wr, mask_wr, tx_done, rx_done;
    logic [3:0] cpu_cmd;
    logic [1:0] mask_val;
    logic       cmd_stb, ef_active, tx_avail, rx_inhib, irq_n;
    logic       err_interval, err_prohibit, err_rate;
    logic [3:0] cmd_code;

    int total = 0;
    int bad   = 0;
    int stb_cnt = 0;
    logic [3:0] last_code = '0;
    logic finished = 1'b0;

    cmdflag_timing_unit u0 (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .fast_rate(fast_rate),
        .ef_wr(ef_wr), .ef_val(ef_val), .cpu_wr(cpu_wr), .cpu_cmd(cpu_cmd),
        .mask_wr(mask_wr), .mask_val(mask_val), .tx_done(tx_done), .rx_done(rx_done),
        .cmd_stb(cmd_stb), .cmd_code(cmd_code), .ef_active(ef_active),
        .tx_avail(tx_avail), .rx_inhib(rx_inhib), .irq_n(irq_n),
        .err_interval(err_interval), .err_prohibit(err_prohibit), .err_rate(err_rate)
    );

    always #4 clk = ~clk;

    // observe issued commands at the port
    always @(posedge clk) begin
        if (rst_n && cmd_stb) begin
            stb_cnt   <= stb_cnt + 1;
            last_code <= cmd_code;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] rs);
        @(negedge clk);
        rst_n = 1'b0; rate_sel = rs; fast_rate = 1'b0; ef_wr = 1'b0; ef_val = 1'b0;
        cpu_wr = 1'b0; cpu_cmd = '0; mask_wr = 1'b0; mask_val = '0;
        tx_done = 1'b0; rx_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        stb_cnt = 0;
    endtask

    task automatic write_cmd(input logic [3:0] code);
        @(negedge clk); cpu_wr = 1'b1; cpu_cmd = code;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic set_ef(input logic v);
        @(negedge clk); ef_wr = 1'b1; ef_val = v;
        @(negedge clk); ef_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_mask(input logic [1:0] m);
        @(negedge clk); mask_wr = 1'b1; mask_val = m;
        @(negedge clk); mask_wr = 1'b0;
    endtask

    task automatic t_reset_state;
        do_reset(3'd0);
        chk("R1 tx_avail", int'(tx_avail), 1);
        chk("R1 rx_inhib", int'(rx_inhib), 1);
        chk("R1 irq_n", int'(irq_n), 1);
        chk("R1 cmd_stb", int'(cmd_stb), 0);
        chk("R1 ef_active", int'(ef_active), 0);
        chk("R1 errors", int'({err_interval, err_prohibit, err_rate}), 0);
    endtask

    task automatic t_issue_timing;
        do_reset(3'd0);
        set_ef(1'b1);
        chk("R2 mode on", int'(ef_active), 1);
        write_cmd(4'h1);
        @(negedge clk);
        chk("R2 no strobe yet", int'(cmd_stb), 0);
        @(negedge clk);
        chk("R2 strobe", int'(cmd_stb), 1);
        chk("R2 code", int'(cmd_code), 1);
        @(negedge clk);
        chk("R2 strobe one cycle", int'(cmd_stb), 0);
    endtask

    task automatic t_interval_fast;
        do_reset(3'd0);
        set_ef(1'b1);
        write_cmd(4'h1);
        write_cmd(4'h2);
        repeat (6) @(negedge clk);
        chk("R3 early write flagged", int'(err_interval), 1);
        chk("R3 one command issued", stb_cnt, 1);
        chk("R3 kept first code", int'(last_code), 1);
        repeat (4) @(negedge clk);
        chk("R3 error sticky", int'(err_interval), 1);
        do_reset(3'd0);
        set_ef(1'b1);
        write_cmd(4'h1);
        @(negedge clk);
        write_cmd(4'h2);
        repeat (6) @(negedge clk);
        chk("R3 spaced write ok", int'(err_interval), 0);
        chk("R3 two commands", stb_cnt, 2);
        chk("R3 second code", int'(last_code), 2);
    endtask

    task automatic t_interval_slow;
        do_reset(3'd3);
        write_cmd(4'h1);
        repeat (2) @(negedge clk);
        write_cmd(4'h2);
        repeat (30) @(negedge clk);
        chk("R4 slow clock rejects", int'(err_interval), 1);
        chk("R4 one command", stb_cnt, 1);
        do_reset(3'd3);
        write_cmd(4'h1);
        repeat (19) @(negedge clk);
        write_cmd(4'h2);
        repeat (30) @(negedge clk);
        chk("R4 slow clock accepts", int'(err_interval), 0);
        chk("R4 two commands", stb_cnt, 2);
    endtask

    task automatic t_mode_change;
        do_reset(3'd7);
        write_cmd(4'h1);
        set_ef(1'b1);
        chk("R5 mode held while pending", int'(ef_active), 0);
        repeat (300) @(negedge clk);
        chk("R5 mode applied when idle", int'(ef_active), 1);
        chk("R5 command issued", stb_cnt, 1);
    endtask

    task automatic t_flag_normal;
        do_reset(3'd0);
        write_cmd(4'h3);
        repeat (3) @(negedge clk);
        chk("R8 enable tx clears", int'(tx_avail), 0);
        chk("R8 rx untouched", int'(rx_inhib), 1);
        set_mask(2'b01);
        chk("R9 masked rx no irq", int'(irq_n), 1);
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk);
        chk("R6 flag at pulse start", int'(tx_avail), 1);
        chk("R9 irq asserted", int'(irq_n), 0);
        cpu_wr = 1'b1; cpu_cmd = 4'h3;
        @(negedge clk); cpu_wr = 1'b0;
        chk("R6 window error", int'(err_prohibit), 1);
        chk("R6 not an interval error", int'(err_interval), 0);
        repeat (2) @(negedge clk); tx_done = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 dropped command", int'(tx_avail), 1);
        chk("R6 no extra strobe", stb_cnt, 1);
        write_cmd(4'h3);
        repeat (3) @(negedge clk);
        chk("R8 clear after window", int'(tx_avail), 0);
        chk("R9 irq released", int'(irq_n), 1);
    endtask

    task automatic t_flag_early;
        do_reset(3'd0);
        set_ef(1'b1);
        write_cmd(4'h4);
        repeat (3) @(negedge clk);
        chk("R8 enable rx clears", int'(rx_inhib), 0);
        set_mask(2'b10);
        @(negedge clk); rx_done = 1'b1;
        @(negedge clk);
        chk("R7 no set at start", int'(rx_inhib), 0);
        chk("R7 no irq in pulse", int'(irq_n), 1);
        cpu_wr = 1'b1; cpu_cmd = 4'h4;
        @(negedge clk); cpu_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 still low in pulse", int'(rx_inhib), 0);
        rx_done = 1'b0;
        @(negedge clk);
        chk("R7 set at pulse end", int'(rx_inhib), 1);
        chk("R9 irq on rx", int'(irq_n), 0);
        chk("R7 no window error", int'(err_prohibit), 0);
        chk("R7 command accepted", stb_cnt, 2);
        set_mask(2'b00);
        chk("R9 mask off releases", int'(irq_n), 1);
    endtask

    task automatic t_rate_check;
        do_reset(3'd0);
        fast_rate = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 zero select legal", int'(err_rate), 0);
        rate_sel = 3'd2;
        @(negedge clk);
        chk("R10 nonzero flagged", int'(err_rate), 1);
        rate_sel = 3'd0;
        repeat (2) @(negedge clk);
        chk("R10 sticky", int'(err_rate), 1);
    endtask

    initial begin
        t_reset_state();
        t_issue_timing();
        t_interval_fast();
        t_interval_slow();
        t_mode_change();
        t_flag_normal();
        t_flag_early();
        t_rate_check();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule